// File: doc/BRIEF.md
# Configuration Load Entry Sequencer

This block controls the start of a configuration load into volatile configuration memory. It enters configuration mode on any of three triggers: release of the power-on reset, an active-low program request, or a one-cycle refresh command. While it initialises, it holds both its init and done status outputs low. After a parameterised number of clock cycles it raises init. On that rising edge it captures the three mode-select pins, which name the load port.

A port engine outside this block supplies a byte stream. The block ignores every byte until it sees the two-byte synchronisation word 0xBD followed by 0xB3. The header ahead of that word is normally 0xFF filler. Every byte after the synchronisation word is passed out as valid configuration data in the cycle it arrives. Two input strobes report the end of the load: a data-end strobe and a CRC-error strobe, both produced outside. A clean end raises done and puts the block in user mode. An error drops init and halts the block until the next trigger.

Top module: `cfg_load_ctrl`

## Requirements
- R1: While the power-on reset `rstN` is low, `initOut`, `doneOut` and `cfgDataValid` are 0 and `modeLatched` is 0.
- R2: After the last trigger is released, `initOut` stays low for INIT_CYCLES-1 rising clock edges and goes high on edge number INIT_CYCLES.
- R3: A low level on `progReqN` drives `initOut` and `doneOut` low on the next edge, from any phase including user mode, and restarts the initialisation count.
- R4: A one-cycle high pulse on `refreshCmd` drives `initOut` and `doneOut` low on the next edge, from any phase including the halted phase, and starts a new load.
- R5: `modeLatched` takes the value of `modePins` on the edge where `initOut` rises. It ignores `modePins` at all other times.
- R6: While searching, no byte is passed on. This includes 0xFF header bytes, and `cfgDataValid` stays 0 for them.
- R7: A byte 0xBD followed by any byte other than 0xB3 returns the detector to searching. If the following byte is itself 0xBD, the first stage is re-armed, so 0xBD 0xBD 0xB3 still locks.
- R8: Once 0xBD 0xB3 has been accepted, each later byte with `dataValid` high appears on `cfgData` with `cfgDataValid` high in the same cycle.
- R9: A `dataEnd` pulse during loading without `crcErr` sets `doneOut` high on the next edge while `initOut` stays high. From then on, no byte is passed on.
- R10: A `crcErr` pulse during loading drives `initOut` low on the next edge with `doneOut` low. After that, `dataEnd`, the data bytes and the passage of time have no effect until a trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| progReqN | input | 1 | Program request, active low |
| refreshCmd | input | 1 | Refresh command, one-cycle pulse |
| modePins | input | MODE_W | Mode-select pins |
| dataByte | input | BYTE_W | Incoming stream byte |
| dataValid | input | 1 | Byte strobe for `dataByte` |
| crcErr | input | 1 | CRC failure strobe from outside |
| dataEnd | input | 1 | End-of-data strobe from outside |
| initOut | output | 1 | Init status, low while initialising or halted |
| doneOut | output | 1 | Done status, high in user mode |
| modeLatched | output | MODE_W | Mode pins captured at the init rise |
| cfgData | output | BYTE_W | Configuration data byte |
| cfgDataValid | output | 1 | Strobe for `cfgData` |

## Verification
The assertions check on every cycle that done is never high without init, and that a program request or a refresh pulse clears both status outputs on the next edge. They also check that the captured mode holds steady while init stays high, that done rises only after a clean end strobe, and that data is passed on only with init high, done low and an input byte present. The bench scenarios are the only way to show the exact length of the initialisation phase, that 0xFF headers and broken preambles are rejected while 0xBD 0xBD 0xB3 locks, and that the halted phase ignores later strobes until a refresh arrives.

// File: rtl/cfg_load_pkg.sv
`timescale 1ns/1ps
package cfg_load_pkg;
  typedef enum logic [2:0] {
    PH_INIT = 3'd0,
    PH_SCAN = 3'd1,
    PH_LOAD = 3'd2,
    PH_USER = 3'd3,
    PH_HALT = 3'd4
  } phase_t;

  typedef struct packed {
    logic scanEn;
    logic passEn;
    logic latchMode;
  } ctl_strobe_t;

  localparam logic [7:0] SYNC_FIRST  = 8'hBD;
  localparam logic [7:0] SYNC_SECOND = 8'hB3;
endpackage

// File: rtl/cfg_load_ctl.sv
`timescale 1ns/1ps
module cfg_load_ctl
  import cfg_load_pkg::*;
#(
  parameter int INIT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        progReqN,
  input  logic        refreshCmd,
  input  logic        syncHit,
  input  logic        crcErr,
  input  logic        dataEnd,
  output ctl_strobe_t ctl,
  output logic        initOut,
  output logic        doneOut
);
  localparam int CNT_W = (INIT_CYCLES < 2) ? 1 : $clog2(INIT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

  phase_t          phase, phaseNext;
  logic [CNT_W-1:0] initCnt;
  logic            trigger;
  logic            initDone;

  assign trigger  = !progReqN || refreshCmd;
  assign initDone = (phase == PH_INIT) && (initCnt == CNT_LAST);

  always_comb begin
    phaseNext = phase;
    if (trigger) begin
      phaseNext = PH_INIT;
    end else begin
      unique case (phase)
        PH_INIT: if (initDone) phaseNext = PH_SCAN;
        PH_SCAN: if (syncHit) phaseNext = PH_LOAD;
        PH_LOAD: begin
          if (crcErr)       phaseNext = PH_HALT;
          else if (dataEnd) phaseNext = PH_USER;
        end
        PH_USER: phaseNext = PH_USER;
        PH_HALT: phaseNext = PH_HALT;
        default: phaseNext = PH_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_INIT;
      initCnt <= '0;
    end else begin
      phase <= phaseNext;
      if (trigger || phase != PH_INIT) initCnt <= '0;
      else if (!initDone)              initCnt <= initCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.scanEn    = (phase == PH_SCAN);
    ctl.passEn    = (phase == PH_LOAD);
    ctl.latchMode = initDone && !trigger;
  end

  assign initOut = (phase == PH_SCAN) || (phase == PH_LOAD) || (phase == PH_USER);
  assign doneOut = (phase == PH_USER);
endmodule

// File: rtl/cfg_load_dp.sv
`timescale 1ns/1ps
module cfg_load_dp
  import cfg_load_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       ctl,
  input  logic [MODE_W-1:0] modePins,
  input  logic [BYTE_W-1:0] dataByte,
  input  logic              dataValid,
  output logic              syncHit,
  output logic [MODE_W-1:0] modeLatched,
  output logic [BYTE_W-1:0] cfgData,
  output logic              cfgDataValid
);
  localparam logic [BYTE_W-1:0] FIRST_W  = BYTE_W'(SYNC_FIRST);
  localparam logic [BYTE_W-1:0] SECOND_W = BYTE_W'(SYNC_SECOND);

  logic syncArmed;
  logic isFirst, isSecond;

  assign isFirst  = (dataByte == FIRST_W);
  assign isSecond = (dataByte == SECOND_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncArmed <= 1'b0;
    end else if (!ctl.scanEn) begin
      syncArmed <= 1'b0;
    end else if (dataValid) begin
      syncArmed <= isFirst;
    end
  end

  assign syncHit = ctl.scanEn && dataValid && syncArmed && isSecond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeLatched <= '0;
    else if (ctl.latchMode) modeLatched <= modePins;
  end

  assign cfgData      = dataByte;
  assign cfgDataValid = ctl.passEn && dataValid;
endmodule

// File: rtl/cfg_load_ctrl.sv
`timescale 1ns/1ps
module cfg_load_ctrl
  import cfg_load_pkg::*;
#(
  parameter int INIT_CYCLES = 16,
  parameter int BYTE_W      = 8,
  parameter int MODE_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progReqN,
  input  logic              refreshCmd,
  input  logic [MODE_W-1:0] modePins,
  input  logic [BYTE_W-1:0] dataByte,
  input  logic              dataValid,
  input  logic              crcErr,
  input  logic              dataEnd,
  output logic              initOut,
  output logic              doneOut,
  output logic [MODE_W-1:0] modeLatched,
  output logic [BYTE_W-1:0] cfgData,
  output logic              cfgDataValid
);
  ctl_strobe_t ctl;
  logic        syncHit;

  cfg_load_ctl #(.INIT_CYCLES(INIT_CYCLES)) ctl_i (
    .clk(clk), .rstN(rstN), .progReqN(progReqN), .refreshCmd(refreshCmd),
    .syncHit(syncHit), .crcErr(crcErr), .dataEnd(dataEnd),
    .ctl(ctl), .initOut(initOut), .doneOut(doneOut)
  );

  cfg_load_dp #(.BYTE_W(BYTE_W), .MODE_W(MODE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modePins(modePins),
    .dataByte(dataByte), .dataValid(dataValid), .syncHit(syncHit),
    .modeLatched(modeLatched), .cfgData(cfgData), .cfgDataValid(cfgDataValid)
  );
endmodule

// File: rtl/cfg_load_chk.sv
`timescale 1ns/1ps
module cfg_load_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              progReqN,
  input logic              refreshCmd,
  input logic              dataValid,
  input logic              crcErr,
  input logic              dataEnd,
  input logic              initOut,
  input logic              doneOut,
  input logic [MODE_W-1:0] modeLatched,
  input logic              cfgDataValid
);
  p_done_needs_init_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> initOut);

  p_prog_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    !progReqN |=> (!initOut && !doneOut));

  p_refresh_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    refreshCmd |=> (!initOut && !doneOut));

  p_mode_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (initOut && $past(initOut)) |-> $stable(modeLatched));

  p_done_after_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> ($past(dataEnd) && !$past(crcErr)));

  p_pass_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgDataValid |-> (initOut && !doneOut && dataValid));
endmodule

bind cfg_load_ctrl cfg_load_chk #(.MODE_W(MODE_W)) chk_i (
  .clk(clk), .rstN(rstN), .progReqN(progReqN), .refreshCmd(refreshCmd),
  .dataValid(dataValid), .crcErr(crcErr), .dataEnd(dataEnd),
  .initOut(initOut), .doneOut(doneOut), .modeLatched(modeLatched),
  .cfgDataValid(cfgDataValid)
);

// File: tb/cfg_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_load_ctrl_tb_top;
  localparam int NINIT = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progReqN = 1'b1;
  logic       refreshCmd = 1'b0;
  logic [2:0] modePins = 3'b000;
  logic [7:0] dataByte = 8'h00;
  logic       dataValid = 1'b0;
  logic       crcErr = 1'b0;
  logic       dataEnd = 1'b0;
  logic       initOut, doneOut, cfgDataValid;
  logic [2:0] modeLatched;
  logic [7:0] cfgData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_load_ctrl #(.INIT_CYCLES(NINIT), .BYTE_W(8), .MODE_W(3)) dut_i (
    .clk(clk), .rstN(rstN), .progReqN(progReqN), .refreshCmd(refreshCmd),
    .modePins(modePins), .dataByte(dataByte), .dataValid(dataValid),
    .crcErr(crcErr), .dataEnd(dataEnd), .initOut(initOut), .doneOut(doneOut),
    .modeLatched(modeLatched), .cfgData(cfgData), .cfgDataValid(cfgDataValid)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expPass, input string req);
    dataByte  = b;
    dataValid = 1'b1;
    #1;
    check(req, cfgDataValid, expPass);
    if (expPass) check(req, cfgData, b);
    step();
    dataValid = 1'b0;
  endtask

  task automatic waitInit(input string req);
    for (int i = 0; i < NINIT - 1; i++) step();
    check(req, initOut, 0);
    step();
    check(req, initOut, 1);
  endtask

  task automatic t_reset();
    #1;
    check("R1 init", initOut, 0);
    check("R1 done", doneOut, 0);
    check("R1 mode", modeLatched, 0);
    check("R1 pass", cfgDataValid, 0);
    step();
    step();
  endtask

  task automatic t_power_on();
    modePins = 3'b101;
    rstN = 1'b1;
    waitInit("R2 power-on init timing");
    check("R5 mode latched", modeLatched, 3'b101);
    modePins = 3'b010;
    step();
    check("R5 mode ignored later", modeLatched, 3'b101);
  endtask

  task automatic t_preamble();
    sendByte(8'hFF, 0, "R6 header");
    sendByte(8'hFF, 0, "R6 header");
    sendByte(8'hBD, 0, "R7 first");
    sendByte(8'h12, 0, "R7 broken");
    sendByte(8'hB3, 0, "R7 lone second");
    sendByte(8'h77, 0, "R7 not locked");
    sendByte(8'hBD, 0, "R7 rearm a");
    sendByte(8'hBD, 0, "R7 rearm b");
    sendByte(8'hB3, 0, "R7 lock");
    sendByte(8'h5A, 1, "R8 data0");
    step();
    sendByte(8'hBD, 1, "R8 data1");
    sendByte(8'hFF, 1, "R8 data2");
  endtask

  task automatic t_done();
    dataEnd = 1'b1;
    step();
    dataEnd = 1'b0;
    check("R9 done", doneOut, 1);
    check("R9 init", initOut, 1);
    sendByte(8'h33, 0, "R9 no pass in user");
    check("R9 done held", doneOut, 1);
  endtask

  task automatic t_prog();
    modePins = 3'b011;
    progReqN = 1'b0;
    step();
    check("R3 init low", initOut, 0);
    check("R3 done low", doneOut, 0);
    step();
    step();
    progReqN = 1'b1;
    waitInit("R3 restart count");
    check("R5 new mode", modeLatched, 3'b011);
  endtask

  task automatic t_error();
    sendByte(8'hBD, 0, "R7 lock a");
    sendByte(8'hB3, 0, "R7 lock b");
    sendByte(8'h44, 1, "R8 data");
    crcErr = 1'b1;
    step();
    crcErr = 1'b0;
    check("R10 init low", initOut, 0);
    check("R10 done low", doneOut, 0);
    dataEnd = 1'b1;
    step();
    dataEnd = 1'b0;
    check("R10 end ignored", doneOut, 0);
    sendByte(8'h55, 0, "R10 data ignored");
    for (int i = 0; i < NINIT + 3; i++) step();
    check("R10 stays halted", initOut, 0);
  endtask

  task automatic t_refresh();
    modePins = 3'b110;
    refreshCmd = 1'b1;
    step();
    refreshCmd = 1'b0;
    check("R4 init low", initOut, 0);
    waitInit("R4 refresh timing");
    check("R4 mode", modeLatched, 3'b110);
    sendByte(8'hBD, 0, "R4 sync a");
    sendByte(8'hB3, 0, "R4 sync b");
    dataEnd = 1'b1;
    step();
    dataEnd = 1'b0;
    check("R4 done after reload", doneOut, 1);
    refreshCmd = 1'b1;
    step();
    refreshCmd = 1'b0;
    check("R4 leaves user", doneOut, 0);
  endtask

  initial begin
    t_reset();
    t_power_on();
    t_preamble();
    t_done();
    t_prog();
    t_error();
    t_refresh();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule